// File: doc/BRIEF.md
# Console Address Decoder with Mirroring

This block turns a 32-bit processor address into a region choice for a small console-style memory system. The regions are a 2 MB main RAM, a 512 KB boot ROM, a 4 KB scratchpad, a 4 KB peripheral register page and a single cache-control register. For each access it also gives the offset local to the chosen region. Main RAM can be reached through three segment windows of 8 MB each. Inside each window the 2 MB array repeats, so the offset is the address modulo 2 MB. The boot ROM can be reached through three segment aliases. It is read-only, and a write that lands on it raises a write-block flag.

For the peripheral page the block also computes a register index that depends on the access width. A byte access uses the page offset as it is. A halfword access uses the offset shifted right by one, and a word access uses it shifted right by two. A second flag marks an offset that falls inside the populated register span. All outputs are registered, so a result appears one clock after the access is presented. An address that matches no region, or a cycle with no strobe, gives an all-zero output set.

Top module: `console_addr_decoder`

## Requirements
- R1: While `rst` is high, and on the first sample after it, every output is zero.
- R2: A strobed access whose address has bits [31:29] equal to 000, 100 or 101 and bits [28:23] equal to zero selects RAM (`region_sel` bit 0). `local_off` is then the address modulo 2 MB, so the RAM repeats four times in each 8 MB window.
- R3: A strobed access to 0x1FC00000, 0x9FC00000 or 0xBFC00000 plus up to 512 KB selects the ROM (`region_sel` bit 1), with `local_off` equal to the address modulo 512 KB. The byte just past that span is unmapped.
- R4: A write that selects the ROM raises `wr_block`. A read of the ROM leaves `wr_block` low, and `wr_block` is never high with any other region.
- R5: A strobed access in the page 0x1F800000 to 0x1F800FFF selects the scratchpad (`region_sel` bit 2), with `local_off` equal to the address bits [11:0].
- R6: A strobed access in the page 0x1F801000 to 0x1F801FFF selects the register page (`region_sel` bit 3), with `local_off` equal to the address bits [11:0]. `io_reg_idx` is that offset shifted right by 0 when `bus_size` is 0 (byte), by 1 when it is 1 (halfword), and by 2 when it is 2 or 3 (word).
- R7: `io_reg_valid` is high only for a register-page access whose page offset is below 0x880.
- R8: Only a write to exactly 0xFFFE0130 selects the cache-control register (`region_sel` bit 4). A read of that address, or any other address in the 0xFFFE page, selects nothing.
- R9: An access that matches no region, or a cycle in which neither `bus_rd` nor `bus_wr` is high, drives `region_sel`, `local_off`, `io_reg_idx`, `io_reg_valid` and `wr_block` to zero.
- R10: The outputs for an access presented before a rising clock edge appear just after that edge, and at most one bit of `region_sel` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Processor address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 or 3 word |
| region_sel | output | 5 | One-hot region select: RAM, ROM, scratchpad, register page, cache control |
| local_off | output | 21 | Offset inside the selected region |
| io_reg_idx | output | 12 | Width-scaled register index inside the register page |
| io_reg_valid | output | 1 | Register-page offset lies in the populated span |
| wr_block | output | 1 | Write aimed at read-only ROM |

## Verification
The bench builds the block with its default parameters: a 2 MB RAM inside 8 MB windows, a 512 KB ROM, 4 KB pages and a populated register span of 0x880. With these values the mirror wrap is reached at the last word of a window (0xA07FFFFC folds to 0x1FFFFC), as are the first byte past the window and the first byte past the ROM. The last populated register byte (0x87F) and the first byte past it can also be reached. All three access widths are tried on the same register-page address, so that the three index shifts can be compared against each other.

// File: rtl/cad_pkg.sv
package cad_pkg;

  localparam int NUM_REGIONS = 5;
  localparam int RGN_RAM  = 0;
  localparam int RGN_ROM  = 1;
  localparam int RGN_SPAD = 2;
  localparam int RGN_IO   = 3;
  localparam int RGN_CCTL = 4;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_size_e;

  // Segment windows through which main RAM is reachable.
  function automatic logic [31:0] ram_alias_base(input int idx);
    case (idx)
      0:       return 32'h0000_0000;
      1:       return 32'h8000_0000;
      default: return 32'hA000_0000;
    endcase
  endfunction

  // Segment windows through which the boot ROM is reachable.
  function automatic logic [31:0] rom_alias_base(input int idx);
    case (idx)
      0:       return 32'h1FC0_0000;
      1:       return 32'h9FC0_0000;
      default: return 32'hBFC0_0000;
    endcase
  endfunction

endpackage

// File: rtl/cad_window_match.sv
module cad_window_match #(
  parameter logic [31:0] BASE  = 32'h0,
  parameter int          IGN_W = 12
) (
  input  logic [31:IGN_W] addr_hi,
  output logic            hit
);
  // Compares only the bits above the window size; the low bits are don't-care.
  assign hit = (addr_hi == BASE[31:IGN_W]);
endmodule

// File: rtl/cad_io_index.sv
module cad_io_index #(
  parameter int PAGE_AW = 12,
  parameter int IO_SPAN = 32'h880
) (
  input  logic [PAGE_AW-1:0] page_off,
  input  logic [1:0]         acc_size,
  output logic [PAGE_AW-1:0] reg_idx,
  output logic               in_span
);
  import cad_pkg::*;

  always_comb begin
    unique case (acc_size_e'(acc_size))
      ACC_BYTE: reg_idx = page_off;
      ACC_HALF: reg_idx = page_off >> 1;
      default:  reg_idx = page_off >> 2;
    endcase
  end

  assign in_span = (32'(page_off) < 32'(IO_SPAN));
endmodule

// File: rtl/cad_region_decode.sv
module cad_region_decode #(
  parameter int          RAM_AW      = 21,
  parameter int          RAM_WIN_AW  = 23,
  parameter int          RAM_ALIASES = 3,
  parameter int          ROM_AW      = 19,
  parameter int          ROM_ALIASES = 3,
  parameter int          PAGE_AW     = 12,
  parameter int          IO_SPAN     = 32'h880,
  parameter logic [31:0] SPAD_BASE   = 32'h1F80_0000,
  parameter logic [31:0] IO_BASE     = 32'h1F80_1000,
  parameter logic [31:0] CCTL_ADDR   = 32'hFFFE_0130,
  localparam int         OFF_W       = RAM_AW,
  localparam int         NREG        = cad_pkg::NUM_REGIONS
) (
  input  logic [31:0]        addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [1:0]         acc_size,
  output logic [NREG-1:0]    sel_d,
  output logic [OFF_W-1:0]   off_d,
  output logic [PAGE_AW-1:0] idx_d,
  output logic               io_valid_d,
  output logic               block_d
);
  import cad_pkg::*;

  logic [RAM_ALIASES-1:0] ram_hit_v;
  logic [ROM_ALIASES-1:0] rom_hit_v;
  logic                   spad_hit;
  logic                   io_hit;
  logic                   cctl_hit;
  logic                   strobe;
  logic [PAGE_AW-1:0]     raw_idx;
  logic                   raw_span;

  for (genvar g = 0; g < RAM_ALIASES; g++) begin : g_ram_win
    cad_window_match #(.BASE(ram_alias_base(g)), .IGN_W(RAM_WIN_AW)) u_match (
      .addr_hi(addr[31:RAM_WIN_AW]),
      .hit    (ram_hit_v[g])
    );
  end

  for (genvar g = 0; g < ROM_ALIASES; g++) begin : g_rom_win
    cad_window_match #(.BASE(rom_alias_base(g)), .IGN_W(ROM_AW)) u_match (
      .addr_hi(addr[31:ROM_AW]),
      .hit    (rom_hit_v[g])
    );
  end

  cad_window_match #(.BASE(SPAD_BASE), .IGN_W(PAGE_AW)) u_spad (
    .addr_hi(addr[31:PAGE_AW]),
    .hit    (spad_hit)
  );

  cad_window_match #(.BASE(IO_BASE), .IGN_W(PAGE_AW)) u_io (
    .addr_hi(addr[31:PAGE_AW]),
    .hit    (io_hit)
  );

  assign cctl_hit = (addr == CCTL_ADDR);
  assign strobe   = rd | wr;

  cad_io_index #(.PAGE_AW(PAGE_AW), .IO_SPAN(IO_SPAN)) u_idx (
    .page_off(addr[PAGE_AW-1:0]),
    .acc_size(acc_size),
    .reg_idx (raw_idx),
    .in_span (raw_span)
  );

  // The regions do not overlap, so the order of this chain only settles
  // don't-care cases; unmapped or idle cycles leave everything zero.
  always_comb begin
    sel_d      = '0;
    off_d      = '0;
    idx_d      = '0;
    io_valid_d = 1'b0;
    block_d    = 1'b0;
    if (strobe) begin
      if (|ram_hit_v) begin
        sel_d[RGN_RAM] = 1'b1;
        off_d          = OFF_W'(addr[RAM_AW-1:0]);
      end else if (|rom_hit_v) begin
        sel_d[RGN_ROM] = 1'b1;
        off_d          = OFF_W'(addr[ROM_AW-1:0]);
        block_d        = wr;
      end else if (spad_hit) begin
        sel_d[RGN_SPAD] = 1'b1;
        off_d           = OFF_W'(addr[PAGE_AW-1:0]);
      end else if (io_hit) begin
        sel_d[RGN_IO] = 1'b1;
        off_d         = OFF_W'(addr[PAGE_AW-1:0]);
        idx_d         = raw_idx;
        io_valid_d    = raw_span;
      end else if (cctl_hit && wr) begin
        sel_d[RGN_CCTL] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/console_addr_decoder.sv
module console_addr_decoder #(
  parameter int          RAM_AW      = 21,
  parameter int          RAM_WIN_AW  = 23,
  parameter int          RAM_ALIASES = 3,
  parameter int          ROM_AW      = 19,
  parameter int          ROM_ALIASES = 3,
  parameter int          PAGE_AW     = 12,
  parameter int          IO_SPAN     = 32'h880,
  parameter logic [31:0] SPAD_BASE   = 32'h1F80_0000,
  parameter logic [31:0] IO_BASE     = 32'h1F80_1000,
  parameter logic [31:0] CCTL_ADDR   = 32'hFFFE_0130,
  localparam int         OFF_W       = RAM_AW,
  localparam int         NREG        = cad_pkg::NUM_REGIONS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [31:0]        bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [1:0]         bus_size,
  output logic [NREG-1:0]    region_sel,
  output logic [OFF_W-1:0]   local_off,
  output logic [PAGE_AW-1:0] io_reg_idx,
  output logic               io_reg_valid,
  output logic               wr_block
);
  import cad_pkg::*;

  logic [NREG-1:0]    sel_d;
  logic [OFF_W-1:0]   off_d;
  logic [PAGE_AW-1:0] idx_d;
  logic               io_valid_d;
  logic               block_d;

  cad_region_decode #(
    .RAM_AW(RAM_AW), .RAM_WIN_AW(RAM_WIN_AW), .RAM_ALIASES(RAM_ALIASES),
    .ROM_AW(ROM_AW), .ROM_ALIASES(ROM_ALIASES), .PAGE_AW(PAGE_AW),
    .IO_SPAN(IO_SPAN), .SPAD_BASE(SPAD_BASE), .IO_BASE(IO_BASE),
    .CCTL_ADDR(CCTL_ADDR)
  ) u_dec (
    .addr      (bus_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .acc_size  (bus_size),
    .sel_d     (sel_d),
    .off_d     (off_d),
    .idx_d     (idx_d),
    .io_valid_d(io_valid_d),
    .block_d   (block_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      region_sel   <= '0;
      local_off    <= '0;
      io_reg_idx   <= '0;
      io_reg_valid <= 1'b0;
      wr_block     <= 1'b0;
    end else begin
      region_sel   <= sel_d;
      local_off    <= off_d;
      io_reg_idx   <= idx_d;
      io_reg_valid <= io_valid_d;
      wr_block     <= block_d;
    end
  end

  // R10: never two regions at once
  a_r10_one_region: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel));

  // R2: RAM offset follows the presented address modulo the RAM size
  a_r2_ram_mirror: assert property (@(posedge clk) disable iff (rst)
    region_sel[RGN_RAM] |-> (local_off == $past(bus_addr[RAM_AW-1:0])));

  // R4: the write block only accompanies a ROM write
  a_r4_block_rom_write: assert property (@(posedge clk) disable iff (rst)
    wr_block |-> (region_sel[RGN_ROM] && $past(bus_wr)));

  // R7: register-span flag only inside the register page
  a_r7_valid_in_page: assert property (@(posedge clk) disable iff (rst)
    io_reg_valid |-> region_sel[RGN_IO]);

  // R8: cache-control select only from a write
  a_r8_cctl_write_only: assert property (@(posedge clk) disable iff (rst)
    region_sel[RGN_CCTL] |-> $past(bus_wr));

  // R9: idle cycle yields no select
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd || bus_wr) |-> (region_sel == '0));
endmodule

// File: tb/test_console_addr_decoder.sv
module test_console_addr_decoder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [4:0]  sel;
    logic [20:0] off;
    logic [11:0] idx;
    logic        valid;
    logic        blk;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [4:0]  region_sel;
  logic [20:0] local_off;
  logic [11:0] io_reg_idx;
  logic        io_reg_valid;
  logic        wr_block;

  int   checks = 0;
  int   failures = 0;
  exp_t sb_q[$];
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  console_addr_decoder i_console_addr_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_size(bus_size), .region_sel(region_sel),
    .local_off(local_off), .io_reg_idx(io_reg_idx),
    .io_reg_valid(io_reg_valid), .wr_block(wr_block)
  );

  // Expected outputs derived from the requirement text, by address ranges.
  function automatic exp_t model(input logic [31:0] a, input logic r, input logic w,
                                 input logic [1:0] sz, input string tag);
    exp_t e;
    logic [31:0] phys;
    logic        seg_ok;
    int          sh;
    e.sel = '0; e.off = '0; e.idx = '0; e.valid = 1'b0; e.blk = 1'b0; e.tag = tag;
    if (!(r || w)) return e;
    phys   = a & 32'h1FFF_FFFF;
    seg_ok = (a[31:29] == 3'b000) || (a[31:29] == 3'b100) || (a[31:29] == 3'b101);
    sh     = (sz >= 2) ? 2 : int'(sz);
    if (seg_ok && phys < 32'h0080_0000) begin
      e.sel = 5'b00001; e.off = 21'(a % 32'h0020_0000);
    end else if (seg_ok && phys >= 32'h1FC0_0000 && phys < 32'h1FC8_0000) begin
      e.sel = 5'b00010; e.off = 21'(a % 32'h0008_0000); e.blk = w;
    end else if (a >= 32'h1F80_0000 && a < 32'h1F80_1000) begin
      e.sel = 5'b00100; e.off = 21'(a - 32'h1F80_0000);
    end else if (a >= 32'h1F80_1000 && a < 32'h1F80_2000) begin
      e.sel = 5'b01000; e.off = 21'(a - 32'h1F80_1000);
      e.idx = 12'(e.off >> sh); e.valid = (e.off < 21'h880);
    end else if (w && a == 32'hFFFE_0130) begin
      e.sel = 5'b10000;
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic r, input logic w,
                       input logic [1:0] sz, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_size = sz;
    sb_q.push_back(model(a, r, w, sz, tag));
  endtask

  task automatic compare(input exp_t e);
    checks++;
    if (region_sel !== e.sel || local_off !== e.off || io_reg_idx !== e.idx ||
        io_reg_valid !== e.valid || wr_block !== e.blk) begin
      failures++;
      $display("FAIL %s: got sel=%b off=%h idx=%h valid=%b blk=%b exp sel=%b off=%h idx=%h valid=%b blk=%b",
               e.tag, region_sel, local_off, io_reg_idx, io_reg_valid, wr_block,
               e.sel, e.off, e.idx, e.valid, e.blk);
    end
  endtask

  // Monitor: result of the item pushed at the previous negedge is visible
  // just after this rising edge (R10: one-cycle latency).
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst && sb_q.size() > 0) compare(sb_q.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_t zero;
    zero = model(32'h0, 1'b0, 1'b0, 2'd0, "R1");
    // R1: reset holds outputs at zero even with a live access on the bus
    bus_addr = 32'h8000_0010; bus_rd = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    compare(zero);
    @(negedge clk);
    bus_rd = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare(zero); // R1: first sample after reset with idle bus

    // R2: RAM in three segments, mirrored every 2 MB
    drive(32'h0000_0010, 1, 0, 2'd2, "R2");
    drive(32'h8012_3456, 1, 0, 2'd0, "R2");
    drive(32'hA07F_FFFC, 0, 1, 2'd2, "R2");
    drive(32'h0060_0004, 0, 1, 2'd1, "R2");
    drive(32'h0080_0000, 1, 0, 2'd2, "R9");
    drive(32'hC000_0000, 1, 0, 2'd2, "R9");
    // R3 / R4: ROM aliases and write block
    drive(32'h1FC0_0004, 1, 0, 2'd2, "R3");
    drive(32'hBFC7_FFFF, 1, 0, 2'd0, "R3");
    drive(32'h9FC1_0000, 0, 1, 2'd2, "R4");
    drive(32'hBFC0_0100, 0, 1, 2'd1, "R4");
    drive(32'h1FC8_0000, 1, 0, 2'd2, "R3");
    // R5: scratchpad
    drive(32'h1F80_0FFC, 0, 1, 2'd2, "R5");
    drive(32'h1F80_0001, 1, 0, 2'd0, "R5");
    // R6 / R7: register page, three widths on one address
    drive(32'h1F80_1074, 1, 0, 2'd0, "R6");
    drive(32'h1F80_1074, 1, 0, 2'd1, "R6");
    drive(32'h1F80_1074, 0, 1, 2'd2, "R6");
    drive(32'h1F80_1124, 1, 0, 2'd3, "R6");
    drive(32'h1F80_187F, 1, 0, 2'd0, "R7");
    drive(32'h1F80_1880, 1, 0, 2'd0, "R7");
    drive(32'h1F80_1FFE, 0, 1, 2'd1, "R7");
    // R8: cache-control register
    drive(32'hFFFE_0130, 0, 1, 2'd2, "R8");
    drive(32'hFFFE_0130, 1, 0, 2'd2, "R8");
    drive(32'hFFFE_0134, 0, 1, 2'd2, "R8");
    // R9: no strobe on mapped addresses
    drive(32'h8000_0020, 0, 0, 2'd2, "R9");
    drive(32'h1F80_1040, 0, 0, 2'd2, "R9");
    // R10: back-to-back different regions
    drive(32'hBFC0_0000, 1, 0, 2'd2, "R10");
    drive(32'h1F80_0010, 1, 0, 2'd2, "R10");
    drive(32'h0000_0000, 0, 1, 2'd2, "R10");
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    if (sb_q.size() != 0) begin
      failures++; checks++;
      $display("FAIL R10: got %0d pending exp 0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule